// File: doc/BRIEF.md
# Data-link bit-oriented message receiver

This block sits on the data-link channel recovered from the extended-superframe framing bits. Each data-link bit arrives with a one-cycle strobe. The block hunts for 16-bit messages that start with eight ones and a zero, then carry a 6-bit code, then end with a zero. It extracts the code from every well-formed message.

Each captured code goes into a short history. A code is declared when it wins a repetition vote and is not the code already declared. A select input chooses the vote: 4 of the last 5 messages, or 8 of the last 10. On a declaration, the block loads the code into its output register and sets a sticky indication flag. The flag, gated by an enable, drives the interrupt output. Software clears the flag with a one-cycle clear strobe.

Top module: `bom_receiver`

## Requirements
- R1: A message is captured only when the 16 most recent strobed bits, oldest first, read 1111_1111_0_cccccc_0. The six `c` bits are the code, and the first of them received is the code MSB. Frames with a wrong guard bit or closing bit are never captured.
- R2: After a capture, pattern checking pauses for 15 strobed bits and resumes on the 16th, so messages sent back to back with no idle bits are each captured.
- R3: With `persist_long` = 0, a code is declared when it equals at least 4 of the 5 most recent captured codes, itself included.
- R4: With `persist_long` = 1, a code is declared when it equals at least 8 of the 10 most recent captured codes, itself included. It is not declared after only 4 to 7 matches.
- R5: A code that wins the vote is declared only if it differs from the last declared code. The first winning code after reset is always declared, whatever its value.
- R6: On a declaration, `msg_code` takes the new code and `msg_flag` is set. Both change at the third rising clock edge, counting the edge that samples the closing bit of the message.
- R7: `msg_flag` stays set until an edge with `flag_clr` = 1 clears it. When a declaration and a clear fall on the same edge, the flag ends up set.
- R8: `msg_irq` is high exactly when `msg_flag` is 1 and `irq_en` is 1.
- R9: While `rst_n` is low, `msg_code` = 0 and `msg_flag` = 0. Reset also empties the code history and forgets the last declared code.
- R10: On a cycle with `dl_strobe` = 0, the value on `dl_bit` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dl_bit | input | 1 | Data-link bit |
| dl_strobe | input | 1 | Marks `dl_bit` as valid for this cycle |
| persist_long | input | 1 | 0: 4-of-5 vote, 1: 8-of-10 vote |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Clears the indication flag (write-one strobe) |
| msg_code | output | 6 | Last declared code |
| msg_flag | output | 1 | Sticky declaration indication |
| msg_irq | output | 1 | Interrupt, flag gated by enable |

## Verification
The bench sends the same code repeatedly and checks that it is not declared a second time. A design that compared against the history instead of the last declaration would raise the flag again here. It interleaves a stray code inside a 4-of-5 run, and sends the same seven matches in 8-of-10 mode, where a design that applied the wrong window would declare too early. It also sends malformed frames and injects random data on unstrobed cycles; a design with a loose pattern check or a missing strobe gate would capture phantom codes. Two more cases complete the run. In one, a clear lands on the same edge as a declaration. In the other, reset is asserted in the middle of a vote run, so a design that kept its history or last-code memory across reset would declare too early or not at all.

// File: rtl/bom_pkg.sv
package bom_pkg;
  localparam int BOM_FRAME_W    = 16;
  localparam int BOM_CODE_W     = 6;
  localparam int BOM_DEPTH_SHORT = 5;
  localparam int BOM_DEPTH_LONG  = 10;
  localparam int BOM_THR_SHORT   = 4;
  localparam int BOM_THR_LONG    = 8;
endpackage

// File: rtl/bom_frame_sync.sv
module bom_frame_sync
  import bom_pkg::*;
#(
  parameter int FRAME_W = BOM_FRAME_W,
  parameter int CODE_W  = BOM_CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_i,
  input  logic              bit_vld_i,
  output logic              cap_vld_o,
  output logic [CODE_W-1:0] cap_code_o
);
  localparam int CNT_W  = $clog2(FRAME_W);
  localparam int HDR_LO = CODE_W + 2;
  localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] sr_q, sr_n;
  logic [CNT_W-1:0]   hold_q, hold_n;
  logic               cap_vld_q, cap_vld_n;
  logic [CODE_W-1:0]  cap_code_q, cap_code_n;
  logic               hit;

  // next-state: shift on strobe, test the window when not holding off
  always_comb begin
    sr_n       = sr_q;
    hold_n     = hold_q;
    cap_vld_n  = 1'b0;
    cap_code_n = cap_code_q;
    hit        = 1'b0;
    if (bit_vld_i) begin
      sr_n = {sr_q[FRAME_W-2:0], bit_i};
      if (hold_q != '0) begin
        hold_n = hold_q - 1'b1;
      end else begin
        hit = (&sr_n[FRAME_W-1:HDR_LO]) && !sr_n[CODE_W+1] && !sr_n[0];
        if (hit) begin
          cap_vld_n  = 1'b1;
          cap_code_n = sr_n[CODE_W:1];
          hold_n     = HOLD_LOAD;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q       <= '0;
      hold_q     <= '0;
      cap_vld_q  <= 1'b0;
      cap_code_q <= '0;
    end else begin
      sr_q       <= sr_n;
      hold_q     <= hold_n;
      cap_vld_q  <= cap_vld_n;
      cap_code_q <= cap_code_n;
    end
  end

  assign cap_vld_o  = cap_vld_q;
  assign cap_code_o = cap_code_q;

  // R2: two captures are always separated by a full frame of bits
  a_r2_no_back_to_back_capture: assert property (@(posedge clk) disable iff (!rst_n)
    cap_vld_q |=> !cap_vld_q);

  // R10: a capture only ever follows a strobed bit
  a_r10_capture_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    cap_vld_q |-> $past(bit_vld_i));
endmodule

// File: rtl/bom_vote.sv
module bom_vote
  import bom_pkg::*;
#(
  parameter int CODE_W      = BOM_CODE_W,
  parameter int DEPTH_SHORT = BOM_DEPTH_SHORT,
  parameter int DEPTH_LONG  = BOM_DEPTH_LONG,
  parameter int THR_SHORT   = BOM_THR_SHORT,
  parameter int THR_LONG    = BOM_THR_LONG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_vld_i,
  input  logic [CODE_W-1:0] cap_code_i,
  input  logic              long_sel_i,
  output logic              decl_o,
  output logic [CODE_W-1:0] decl_code_o
);
  localparam int OLD_N = DEPTH_LONG - 1;

  logic [CODE_W-1:0] hc_q [OLD_N];
  logic [CODE_W-1:0] hc_n [OLD_N];
  logic [OLD_N-1:0]  hv_q, hv_n;
  logic [OLD_N-1:0]  same_old;
  logic [CODE_W-1:0] prev_q, prev_n;
  logic              prev_vld_q, prev_vld_n;
  logic              decl_q, decl_n;
  logic [CODE_W-1:0] decl_code_q, decl_code_n;
  int                votes;
  int                need;
  logic              fresh;

  // per-entry compare; entries beyond the short window count only in long mode
  for (genvar gi = 0; gi < OLD_N; gi++) begin : g_cmp
    if (gi < DEPTH_SHORT - 1) begin : g_short
      assign same_old[gi] = hv_q[gi] && (hc_q[gi] == cap_code_i);
    end else begin : g_long
      assign same_old[gi] = long_sel_i && hv_q[gi] && (hc_q[gi] == cap_code_i);
    end
  end

  always_comb begin
    votes = 1 + $countones(same_old);
    need  = long_sel_i ? THR_LONG : THR_SHORT;
    fresh = !prev_vld_q || (cap_code_i != prev_q);
  end

  always_comb begin
    hc_n        = hc_q;
    hv_n        = hv_q;
    prev_n      = prev_q;
    prev_vld_n  = prev_vld_q;
    decl_n      = 1'b0;
    decl_code_n = decl_code_q;
    if (cap_vld_i) begin
      hc_n[0] = cap_code_i;
      for (int i = 1; i < OLD_N; i++) hc_n[i] = hc_q[i-1];
      hv_n = {hv_q[OLD_N-2:0], 1'b1};
      if ((votes >= need) && fresh) begin
        decl_n      = 1'b1;
        decl_code_n = cap_code_i;
        prev_n      = cap_code_i;
        prev_vld_n  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < OLD_N; i++) hc_q[i] <= '0;
      hv_q        <= '0;
      prev_q      <= '0;
      prev_vld_q  <= 1'b0;
      decl_q      <= 1'b0;
      decl_code_q <= '0;
    end else begin
      hc_q        <= hc_n;
      hv_q        <= hv_n;
      prev_q      <= prev_n;
      prev_vld_q  <= prev_vld_n;
      decl_q      <= decl_n;
      decl_code_q <= decl_code_n;
    end
  end

  assign decl_o      = decl_q;
  assign decl_code_o = decl_code_q;

  // R3: a declaration is always the result of a capture one cycle earlier
  a_r3_decl_follows_capture: assert property (@(posedge clk) disable iff (!rst_n)
    decl_q |-> $past(cap_vld_i));

  // R5: the same message cannot be declared on two consecutive cycles
  a_r5_single_declaration: assert property (@(posedge clk) disable iff (!rst_n)
    decl_q |=> !decl_q);
endmodule

// File: rtl/bom_flag.sv
module bom_flag
  import bom_pkg::*;
#(
  parameter int CODE_W = BOM_CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              decl_i,
  input  logic [CODE_W-1:0] decl_code_i,
  input  logic              clr_i,
  input  logic              irq_en_i,
  output logic [CODE_W-1:0] code_o,
  output logic              flag_o,
  output logic              irq_o
);
  logic [CODE_W-1:0] code_q, code_n;
  logic              ind_q, ind_n;

  // set wins over clear
  always_comb begin
    code_n = code_q;
    ind_n  = ind_q;
    if (decl_i) begin
      code_n = decl_code_i;
      ind_n  = 1'b1;
    end else if (clr_i) begin
      ind_n  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      ind_q  <= 1'b0;
    end else begin
      code_q <= code_n;
      ind_q  <= ind_n;
    end
  end

  assign code_o = code_q;
  assign flag_o = ind_q;
  assign irq_o  = ind_q & irq_en_i;

  // R6: a declaration loads the code and raises the flag on the next edge
  a_r6_load_on_declare: assert property (@(posedge clk) disable iff (!rst_n)
    decl_i |=> (code_q == $past(decl_code_i)) && ind_q);

  // R7: without a clear the flag holds
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ind_q && !clr_i) |=> ind_q);

  // R7: a clear with no competing declaration drops the flag
  a_r7_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !decl_i) |=> !ind_q);
endmodule

// File: rtl/bom_receiver.sv
module bom_receiver
  import bom_pkg::*;
#(
  parameter int FRAME_W     = BOM_FRAME_W,
  parameter int CODE_W      = BOM_CODE_W,
  parameter int DEPTH_SHORT = BOM_DEPTH_SHORT,
  parameter int DEPTH_LONG  = BOM_DEPTH_LONG,
  parameter int THR_SHORT   = BOM_THR_SHORT,
  parameter int THR_LONG    = BOM_THR_LONG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dl_bit,
  input  logic              dl_strobe,
  input  logic              persist_long,
  input  logic              irq_en,
  input  logic              flag_clr,
  output logic [CODE_W-1:0] msg_code,
  output logic              msg_flag,
  output logic              msg_irq
);
  logic              cap_vld;
  logic [CODE_W-1:0] cap_code;
  logic              decl;
  logic [CODE_W-1:0] decl_code;

  bom_frame_sync #(
    .FRAME_W (FRAME_W),
    .CODE_W  (CODE_W)
  ) i_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_i      (dl_bit),
    .bit_vld_i  (dl_strobe),
    .cap_vld_o  (cap_vld),
    .cap_code_o (cap_code)
  );

  bom_vote #(
    .CODE_W      (CODE_W),
    .DEPTH_SHORT (DEPTH_SHORT),
    .DEPTH_LONG  (DEPTH_LONG),
    .THR_SHORT   (THR_SHORT),
    .THR_LONG    (THR_LONG)
  ) i_vote (
    .clk         (clk),
    .rst_n       (rst_n),
    .cap_vld_i   (cap_vld),
    .cap_code_i  (cap_code),
    .long_sel_i  (persist_long),
    .decl_o      (decl),
    .decl_code_o (decl_code)
  );

  bom_flag #(
    .CODE_W (CODE_W)
  ) i_flag (
    .clk         (clk),
    .rst_n       (rst_n),
    .decl_i      (decl),
    .decl_code_i (decl_code),
    .clr_i       (flag_clr),
    .irq_en_i    (irq_en),
    .code_o      (msg_code),
    .flag_o      (msg_flag),
    .irq_o       (msg_irq)
  );

  // R8: interrupt never rises without the enable
  a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    msg_irq |-> irq_en);
endmodule

// File: tb/test_bom_receiver.sv
`timescale 1ns/1ps
module test_bom_receiver;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       dl_bit, dl_strobe, persist_long, irq_en, flag_clr;
  logic [5:0] msg_code;
  logic       msg_flag, msg_irq;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  bom_receiver i_bom_receiver (
    .clk(clk), .rst_n(rst_n), .dl_bit(dl_bit), .dl_strobe(dl_strobe),
    .persist_long(persist_long), .irq_en(irq_en), .flag_clr(flag_clr),
    .msg_code(msg_code), .msg_flag(msg_flag), .msg_irq(msg_irq));

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  // behavioural reference model
  bit [15:0] m_sr;
  int        m_hold;
  bit [5:0]  m_hist[$];
  bit        m_pv;
  bit [5:0]  m_prev;
  bit [5:0]  m_code;
  bit        m_ind;
  bit        p0v, p1v;
  bit [5:0]  p0c, p1c;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sr = 0; m_hold = 0; m_hist.delete(); m_pv = 0; m_prev = 0;
      m_code = 0; m_ind = 0; p0v = 0; p1v = 0; p0c = 0; p1c = 0;
    end else begin
      if (p1v) begin m_code = p1c; m_ind = 1; end
      else if (flag_clr) m_ind = 0;
      p1v = p0v; p1c = p0c; p0v = 0;
      if (dl_strobe) begin
        m_sr = {m_sr[14:0], dl_bit};
        if (m_hold > 0) m_hold--;
        else if (m_sr[15:8] == 8'hFF && !m_sr[7] && !m_sr[0]) begin
          bit [5:0] c;
          int w, n;
          c = m_sr[6:1];
          m_hold = 15;
          m_hist.push_front(c);
          if (m_hist.size() > 10) void'(m_hist.pop_back());
          w = persist_long ? 10 : 5;
          n = 0;
          for (int i = 0; i < w && i < m_hist.size(); i++) if (m_hist[i] == c) n++;
          if (n >= (persist_long ? 8 : 4) && (!m_pv || c != m_prev)) begin
            m_pv = 1; m_prev = c; p0v = 1; p0c = c;
          end
        end
      end
    end
  end

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      chk("R6 model msg_code", msg_code, m_code);
      chk("R7 model msg_flag", msg_flag, m_ind);
      chk("R8 model msg_irq", msg_irq, m_ind & irq_en);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input bit b, input bit gap);
    if (gap) begin
      dl_strobe = 1'b0; dl_bit = 1'($urandom);
      @(negedge clk);
    end
    dl_bit = b; dl_strobe = 1'b1;
    @(negedge clk);
    dl_strobe = 1'b0; dl_bit = 1'b0;
  endtask

  // kind 0: good, 1: closing bit wrong, 2: guard bit wrong
  task automatic send_frame(input bit [5:0] c, input int kind, input bit gap);
    bit [15:0] f;
    f = {8'hFF, kind == 2, c, kind == 1};
    for (int i = 15; i >= 0; i--) send_bit(f[i], gap);
  endtask

  task automatic send_n(input bit [5:0] c, input int n);
    for (int k = 0; k < n; k++) send_frame(c, 0, 1'b0);
  endtask

  initial begin
    #500000;
    bad++; total++;
    $display("FAIL watchdog expired got=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; dl_bit = 0; dl_strobe = 0; persist_long = 0; irq_en = 1; flag_clr = 0;
    idle(3);
    chk("R9 reset msg_code", msg_code, 0);
    chk("R9 reset msg_flag", msg_flag, 0);
    chk("R9 reset msg_irq", msg_irq, 0);
    rst_n = 1'b1;
    idle(2);

    // 4-of-5, back-to-back frames
    send_n(6'h2D, 3); idle(4);
    chk("R3 three matches no declare", msg_flag, 0);
    send_n(6'h2D, 1); idle(4);
    chk("R2/R3 fourth declares flag", msg_flag, 1);
    chk("R6 code loaded", msg_code, 6'h2D);
    chk("R8 irq with enable", msg_irq, 1);

    irq_en = 0; idle(1);
    chk("R8 irq masked", msg_irq, 0);
    chk("R7 flag sticky", msg_flag, 1);
    flag_clr = 1; idle(1); flag_clr = 0; idle(1);
    chk("R7 clear drops flag", msg_flag, 0);
    irq_en = 1;

    // repeat of declared code
    send_n(6'h2D, 5); idle(4);
    chk("R5 same code not redeclared", msg_flag, 0);
    chk("R5 code unchanged", msg_code, 6'h2D);

    // stray code inside run
    send_n(6'h13, 3); send_n(6'h05, 1); idle(4);
    chk("R3 stray breaks run", msg_flag, 0);
    send_n(6'h13, 1); idle(4);
    chk("R3 four of five with stray", msg_flag, 1);
    chk("R3 code B", msg_code, 6'h13);
    flag_clr = 1; idle(1); flag_clr = 0;

    // malformed frames
    for (int k = 0; k < 5; k++) send_frame(6'h15, 1, 1'b0);
    for (int k = 0; k < 5; k++) send_frame(6'h15, 2, 1'b0);
    idle(4);
    chk("R1 malformed ignored flag", msg_flag, 0);
    chk("R1 malformed ignored code", msg_code, 6'h13);

    // 8-of-10
    persist_long = 1; idle(1);
    send_n(6'h3C, 7); idle(4);
    chk("R4 seven matches no declare", msg_flag, 0);
    send_n(6'h3C, 1); idle(4);
    chk("R4 eighth declares", msg_flag, 1);
    chk("R4 code D", msg_code, 6'h3C);
    flag_clr = 1; idle(1); flag_clr = 0;
    persist_long = 0; idle(1);

    // unstrobed noise between bits
    for (int k = 0; k < 4; k++) send_frame(6'h0A, 0, 1'b1);
    idle(4);
    chk("R10 gaps ignored flag", msg_flag, 1);
    chk("R10 gaps ignored code", msg_code, 6'h0A);

    // declare and clear on same edge
    send_n(6'h21, 3);
    flag_clr = 1;
    send_frame(6'h21, 0, 1'b0);
    idle(2);
    flag_clr = 0;
    idle(3);
    chk("R7 set wins over clear", msg_flag, 1);
    chk("R7 code G", msg_code, 6'h21);
    flag_clr = 1; idle(1); flag_clr = 0;

    // reset mid-run clears history and last code
    send_n(6'h21, 3);
    rst_n = 0; idle(2); rst_n = 1; idle(1);
    chk("R9 code after reset", msg_code, 0);
    send_n(6'h21, 1); idle(4);
    chk("R9 history emptied", msg_flag, 0);
    send_n(6'h21, 3); idle(4);
    chk("R5 first after reset declared", msg_flag, 1);
    chk("R5 code after reset", msg_code, 6'h21);

    idle(5);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule